// File: doc/BRIEF.md
# Register-Color Signature Store Buffer

This block is a small fully associative buffer that passes data from stores to later loads without any effective-address arithmetic. Every architectural register carries a version color. A register write hands that register a fresh color from a wrap-around counter. A memory operation is tagged by joining the current color of its base register with its signed displacement. Two operations with the same tag are treated as touching the same location. The tag needs only the decoded displacement and the color table, so it can be formed early in a pipeline.

A store inserts its data under its tag. A load looks its tag up in the same cycle and gets either a hit with data or a miss. The caller then falls back to the normal memory path. A flush input empties the buffer. Address generation, cache access, speculation recovery and checking against real addresses are left to the surrounding logic.

Top module: `sigbuf`

## Requirements
- R1: After reset every buffer entry is invalid, so every load misses, and register i holds color i.
- R2: The tag of an operation is {color of its base register (6 bits, upper), displacement (16 bits, lower)}. A load whose tag equals the tag of a stored entry hits and returns that entry's data. A load with a different displacement misses.
- R3: A register-write notify gives the register a color no other register holds. After it, loads through that register miss on entries stored under its old color, and two distinct registers never share a color.
- R4: A store whose tag is already present overwrites that entry's data in place and does not use another entry. No two valid entries ever hold the same tag.
- R5: A store with a new tag fills the lowest-numbered invalid entry. When all 8 entries are valid, it replaces the entry chosen by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one after each replacement.
- R6: Lookup is combinational: hit and data reflect the load inputs in the same cycle. With the load enable low the hit output is 0, and the data output is 0 whenever hit is 0.
- R7: A store and an enabled load with equal tags in the same cycle make the load hit with the store's data.
- R8: A register-write notify and a store or load in the same cycle form their tags with the register's color from before the notify.
- R9: Colors for notifies come from a 6-bit counter that starts at 32 after reset and counts up. A notify that arrives while the counter is at 63 does three things: it invalidates every entry, it returns every register to color equal to its index, and it restarts the counter at 32. A store in that same cycle is dropped.
- R10: A flush invalidates all entries in one cycle. A store in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register-write notify strobe |
| regWrIdx | input | 5 | Register being written |
| stEn | input | 1 | Store insert strobe |
| stBase | input | 5 | Store base register |
| stDisp | input | 16 | Store displacement |
| stData | input | 32 | Store data |
| ldEn | input | 1 | Load lookup enable |
| ldBase | input | 5 | Load base register |
| ldDisp | input | 16 | Load displacement |
| flushEn | input | 1 | Invalidate every entry |
| ldHit | output | 1 | Load found its tag |
| ldData | output | 32 | Data for a hit, zero otherwise |

## Verification
Several functions can meet in one cycle. The two that matter most are a register-write notify and a store or load through that same register: the tag must use the color from before the notify. The bench drives both in the same cycle through one register. A following load must then miss, because the entry sits under the retired color. A store meeting a load with the same tag is provoked the same way and must forward in that cycle. The random phase keeps bases and displacements in a narrow range so that such collisions, counter wraps and replacements happen often. Each cycle is compared with a bench model built from the requirements.

// File: rtl/sigbuf_pkg.sv
package sigbuf_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic clearAll;    // invalidate every entry
    logic recolorAll;  // return every register to its identity color
    logic colorWe;     // write newColor into the notified register
    logic stWrite;     // write the store into entry stSlot
  } ctrl_t;

endpackage

// File: rtl/sigbuf_ctrl.sv
module sigbuf_ctrl
  import sigbuf_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int COLOR_W  = 6,
  parameter int NUM_REGS = 32,
  localparam int SLOT_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               stEn,
  input  logic               flushEn,
  input  logic [DEPTH-1:0]   stMatch,
  input  logic [DEPTH-1:0]   validVec,
  output ctrl_t              strb,
  output logic [SLOT_W-1:0]  stSlot,
  output logic [COLOR_W-1:0] newColor
);

  localparam logic [COLOR_W-1:0] COLOR_MAX   = '1;
  localparam logic [COLOR_W-1:0] COLOR_FIRST = COLOR_W'(NUM_REGS);
  localparam logic [SLOT_W-1:0]  SLOT_LAST   = SLOT_W'(DEPTH - 1);

  logic [COLOR_W-1:0] colorCnt;
  logic [SLOT_W-1:0]  rrPtr;
  logic [SLOT_W-1:0]  matchIdx;
  logic [SLOT_W-1:0]  freeIdx;
  logic               anyMatch;
  logic               anyFree;
  logic               wrapEv;
  logic               replaceEv;

  assign wrapEv   = regWrEn && (colorCnt == COLOR_MAX);
  assign newColor = colorCnt;
  assign anyMatch = |stMatch;
  assign anyFree  = ~&validVec;

  always_comb begin
    strb.clearAll   = flushEn || wrapEv;
    strb.recolorAll = wrapEv;
    strb.colorWe    = regWrEn && !wrapEv;
    strb.stWrite    = stEn && !(flushEn || wrapEv);
  end

  // Index of the matching entry (at most one is set)
  always_comb begin
    matchIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (stMatch[i]) matchIdx = SLOT_W'(i);
    end
  end

  // Lowest-numbered invalid entry
  always_comb begin
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = SLOT_W'(i);
    end
  end

  always_comb begin
    if (anyMatch)     stSlot = matchIdx;
    else if (anyFree) stSlot = freeIdx;
    else              stSlot = rrPtr;
  end

  assign replaceEv = strb.stWrite && !anyMatch && !anyFree;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colorCnt <= COLOR_FIRST;
      rrPtr    <= '0;
    end else begin
      if (wrapEv)       colorCnt <= COLOR_FIRST;
      else if (regWrEn) colorCnt <= colorCnt + 1'b1;
      if (replaceEv)    rrPtr <= (rrPtr == SLOT_LAST) ? '0 : rrPtr + 1'b1;
    end
  end

  // R9: colors handed out never fall into the identity range
  a_r9_color_floor: assert property (@(posedge clk) disable iff (!rstN)
    colorCnt >= COLOR_FIRST);

  // R9: a notify at the top of the range restarts the counter
  a_r9_wrap_restart: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && colorCnt == COLOR_MAX) |=> colorCnt == COLOR_FIRST);

  // R5: a new tag with room available never lands on a valid entry
  a_r5_fill_free: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stWrite && !anyMatch && anyFree) |-> !validVec[stSlot]);

  // R5: the replacement pointer moves only on a replacement
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !replaceEv |=> $stable(rrPtr));

endmodule

// File: rtl/sigbuf_dp.sv
module sigbuf_dp
  import sigbuf_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int COLOR_W  = 6,
  parameter int DISP_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  localparam int SLOT_W  = $clog2(DEPTH),
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int KEY_W   = COLOR_W + DISP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              strb,
  input  logic [SLOT_W-1:0]  stSlot,
  input  logic [COLOR_W-1:0] newColor,
  input  logic [REG_W-1:0]   regWrIdx,
  input  logic               stEn,
  input  logic [REG_W-1:0]   stBase,
  input  logic [DISP_W-1:0]  stDisp,
  input  logic [DATA_W-1:0]  stData,
  input  logic               ldEn,
  input  logic [REG_W-1:0]   ldBase,
  input  logic [DISP_W-1:0]  ldDisp,
  output logic [DEPTH-1:0]   stMatch,
  output logic [DEPTH-1:0]   validVec,
  output logic               ldHit,
  output logic [DATA_W-1:0]  ldData
);

  logic [COLOR_W-1:0] colorTab [NUM_REGS];
  logic [KEY_W-1:0]   keyTab   [DEPTH];
  logic [DATA_W-1:0]  dataTab  [DEPTH];
  logic [DEPTH-1:0]   ldMatch;
  logic [KEY_W-1:0]   stKey;
  logic [KEY_W-1:0]   ldKey;
  logic [DATA_W-1:0]  bufData;
  logic               fwdHit;

  // Tags use the color held before any update this cycle
  assign stKey = {colorTab[stBase], stDisp};
  assign ldKey = {colorTab[ldBase], ldDisp};

  always_ff @(posedge clk) begin
    if (!rstN || strb.recolorAll) begin
      for (int r = 0; r < NUM_REGS; r++) colorTab[r] <= COLOR_W'(r);
    end else if (strb.colorWe) begin
      colorTab[regWrIdx] <= newColor;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    assign stMatch[e] = validVec[e] && (keyTab[e] == stKey);
    assign ldMatch[e] = validVec[e] && (keyTab[e] == ldKey);

    always_ff @(posedge clk) begin
      if (!rstN || strb.clearAll) begin
        validVec[e] <= 1'b0;
      end else if (strb.stWrite && stSlot == SLOT_W'(e)) begin
        validVec[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strb.stWrite && stSlot == SLOT_W'(e)) begin
        keyTab[e]  <= stKey;
        dataTab[e] <= stData;
      end
    end
  end

  always_comb begin
    bufData = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (ldMatch[e]) bufData = bufData | dataTab[e];
    end
  end

  assign fwdHit = stEn && (stKey == ldKey);
  assign ldHit  = ldEn && (fwdHit || (|ldMatch));
  assign ldData = !ldHit ? '0 : (fwdHit ? stData : bufData);

  // R4: a tag is never held by two valid entries
  a_r4_unique_ld: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ldMatch));
  a_r4_unique_st: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stMatch));

  // R10: a clear strobe empties the buffer by the next cycle
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> validVec == '0);

  // R3: a notify always changes the register's color
  a_r3_fresh_color: assert property (@(posedge clk) disable iff (!rstN)
    strb.colorWe |=> colorTab[$past(regWrIdx)] != $past(colorTab[regWrIdx]));

endmodule

// File: rtl/sigbuf.sv
module sigbuf
  import sigbuf_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int COLOR_W  = 6,
  parameter int DISP_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  localparam int SLOT_W  = $clog2(DEPTH),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrIdx,
  input  logic              stEn,
  input  logic [REG_W-1:0]  stBase,
  input  logic [DISP_W-1:0] stDisp,
  input  logic [DATA_W-1:0] stData,
  input  logic              ldEn,
  input  logic [REG_W-1:0]  ldBase,
  input  logic [DISP_W-1:0] ldDisp,
  input  logic              flushEn,
  output logic              ldHit,
  output logic [DATA_W-1:0] ldData
);

  ctrl_t              strb;
  logic [SLOT_W-1:0]  stSlot;
  logic [COLOR_W-1:0] newColor;
  logic [DEPTH-1:0]   stMatch;
  logic [DEPTH-1:0]   validVec;

  sigbuf_ctrl #(
    .DEPTH(DEPTH), .COLOR_W(COLOR_W), .NUM_REGS(NUM_REGS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .stEn(stEn),
    .flushEn(flushEn), .stMatch(stMatch), .validVec(validVec),
    .strb(strb), .stSlot(stSlot), .newColor(newColor)
  );

  sigbuf_dp #(
    .DEPTH(DEPTH), .COLOR_W(COLOR_W), .DISP_W(DISP_W),
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stSlot(stSlot),
    .newColor(newColor), .regWrIdx(regWrIdx), .stEn(stEn),
    .stBase(stBase), .stDisp(stDisp), .stData(stData),
    .ldEn(ldEn), .ldBase(ldBase), .ldDisp(ldDisp),
    .stMatch(stMatch), .validVec(validVec),
    .ldHit(ldHit), .ldData(ldData)
  );

  // R6: a disabled lookup never reports a hit
  a_r6_idle_miss: assert property (@(posedge clk) disable iff (!rstN)
    !ldEn |-> !ldHit);

endmodule

// File: tb/sigbuf_tb.sv
module sigbuf_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [4:0]  regWrIdx;
  logic        stEn;
  logic [4:0]  stBase;
  logic [15:0] stDisp;
  logic [31:0] stData;
  logic        ldEn;
  logic [4:0]  ldBase;
  logic [15:0] ldDisp;
  logic        flushEn;
  logic        ldHit;
  logic [31:0] ldData;

  always #10 clk = ~clk;

  sigbuf u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .stEn(stEn), .stBase(stBase), .stDisp(stDisp), .stData(stData),
    .ldEn(ldEn), .ldBase(ldBase), .ldDisp(ldDisp), .flushEn(flushEn),
    .ldHit(ldHit), .ldData(ldData)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model built from the requirements
  logic [5:0]  mColor [32];
  logic [5:0]  mCnt;
  logic        mValid [8];
  logic [21:0] mKey   [8];
  logic [31:0] mData  [8];
  int          mPtr;

  function automatic logic [21:0] mkKey(int base, int disp);
    return {mColor[base], 16'(disp)};
  endfunction

  task automatic modelReset();
    for (int r = 0; r < 32; r++) mColor[r] = 6'(r);
    for (int e = 0; e < 8; e++) begin
      mValid[e] = 0; mKey[e] = '0; mData[e] = '0;
    end
    mCnt = 6'd32;
    mPtr = 0;
  endtask

  task automatic expLookup(output logic hit, output logic [31:0] dat);
    logic [21:0] lk;
    hit = 0; dat = '0;
    if (!ldEn) return;
    lk = mkKey(int'(ldBase), int'(ldDisp));
    if (stEn && mkKey(int'(stBase), int'(stDisp)) == lk) begin
      hit = 1; dat = stData; return;
    end
    for (int e = 0; e < 8; e++) begin
      if (mValid[e] && mKey[e] == lk) begin hit = 1; dat = mData[e]; end
    end
  endtask

  task automatic modelStep();
    logic [21:0] sk;
    logic wrap;
    int slot;
    sk = mkKey(int'(stBase), int'(stDisp));
    wrap = regWrEn && (mCnt == 6'd63);
    if (flushEn || wrap) begin
      for (int e = 0; e < 8; e++) mValid[e] = 0;
    end else if (stEn) begin
      slot = -1;
      for (int e = 0; e < 8; e++) if (mValid[e] && mKey[e] == sk) slot = e;
      if (slot < 0) begin
        for (int e = 7; e >= 0; e--) if (!mValid[e]) slot = e;
      end
      if (slot < 0) begin
        slot = mPtr;
        mPtr = (mPtr + 1) % 8;
      end
      mValid[slot] = 1; mKey[slot] = sk; mData[slot] = stData;
    end
    if (wrap) begin
      for (int r = 0; r < 32; r++) mColor[r] = 6'(r);
      mCnt = 6'd32;
    end else if (regWrEn) begin
      mColor[regWrIdx] = mCnt;
      mCnt = mCnt + 6'd1;
    end
  endtask

  task automatic idle();
    regWrEn = 0; regWrIdx = '0; stEn = 0; stBase = '0; stDisp = '0;
    stData = '0; ldEn = 0; ldBase = '0; ldDisp = '0; flushEn = 0;
  endtask

  // Inputs are already driven (after a falling edge); check, then clock
  task automatic cycle(string tag);
    logic eh;
    logic [31:0] ed;
    #5;
    expLookup(eh, ed);
    if (ldEn || tag == "R6") begin
      total++;
      if (ldHit !== eh || ldData !== ed) begin
        bad++;
        $display("FAIL %s: hit=%0b data=%08h expected hit=%0b data=%08h",
                 tag, ldHit, ldData, eh, ed);
      end
    end
    @(posedge clk);
    modelStep();
    @(negedge clk);
    idle();
  endtask

  task automatic doLoad(int b, int d, string tag);
    ldEn = 1; ldBase = 5'(b); ldDisp = 16'(d);
    cycle(tag);
  endtask

  task automatic doStore(int b, int d, logic [31:0] v, string tag);
    stEn = 1; stBase = 5'(b); stDisp = 16'(d); stData = v;
    cycle(tag);
  endtask

  task automatic doNotify(int r, string tag);
    regWrEn = 1; regWrIdx = 5'(r);
    cycle(tag);
  endtask

  task automatic expectFixed(logic eh, logic [31:0] ed, string tag);
    total++;
    if (ldHit !== eh || ldData !== ed) begin
      bad++;
      $display("FAIL %s: hit=%0b data=%08h expected hit=%0b data=%08h",
               tag, ldHit, ldData, eh, ed);
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    modelReset();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1: empty after reset; identity colors keep registers apart
    for (int r = 0; r < 4; r++) doLoad(r, 0, "R1");

    // R2: matching tag hits, other displacement or register misses
    doStore(1, 4, 32'hA1A1_0001, "R2");
    ldEn = 1; ldBase = 5'd1; ldDisp = 16'd4; #5;
    expectFixed(1'b1, 32'hA1A1_0001, "R2");
    @(posedge clk); modelStep(); @(negedge clk); idle();
    doLoad(1, 5, "R2");
    doLoad(1, 16'hFFFC, "R2");
    doLoad(2, 4, "R3");

    // R6: matching tag with enable low reports nothing
    ldEn = 0; ldBase = 5'd1; ldDisp = 16'd4;
    cycle("R6");

    // R3: a notify retires the old color
    doNotify(1, "R3");
    doLoad(1, 4, "R3");

    // R8: notify and store together use the color from before
    regWrEn = 1; regWrIdx = 5'd2;
    stEn = 1; stBase = 5'd2; stDisp = 16'd8; stData = 32'hB2B2_0002;
    ldEn = 1; ldBase = 5'd2; ldDisp = 16'd8;
    cycle("R8");
    ldEn = 1; ldBase = 5'd2; ldDisp = 16'd8; #5;
    expectFixed(1'b0, 32'h0, "R8");
    @(posedge clk); modelStep(); @(negedge clk); idle();

    // R7: store and load on one tag in one cycle forward
    doStore(3, 1, 32'hC3C3_0003, "R7");
    stEn = 1; stBase = 5'd3; stDisp = 16'd1; stData = 32'hD4D4_0004;
    ldEn = 1; ldBase = 5'd3; ldDisp = 16'd1;
    #5; expectFixed(1'b1, 32'hD4D4_0004, "R7");
    #0; cycle("R7");

    // R4: overwrite in place keeps a single entry
    doLoad(3, 1, "R4");
    doStore(3, 1, 32'hE5E5_0005, "R4");
    doLoad(3, 1, "R4");

    // R5: fill all entries, then round-robin replacement from entry 0
    flushEn = 1; cycle("R10");
    for (int d = 0; d < 8; d++) doStore(0, d, 32'h5000_0000 + d, "R5");
    for (int d = 0; d < 8; d++) doLoad(0, d, "R5");
    doStore(0, 8, 32'h5000_0008, "R5");
    ldEn = 1; ldBase = 5'd0; ldDisp = 16'd0; #5;
    expectFixed(1'b0, 32'h0, "R5");
    @(posedge clk); modelStep(); @(negedge clk); idle();
    doStore(0, 9, 32'h5000_0009, "R5");
    doLoad(0, 1, "R5");
    doLoad(0, 2, "R5");
    doLoad(0, 9, "R5");
    doStore(0, 3, 32'h5333_0003, "R4");
    doLoad(0, 3, "R4");

    // R10: flush drops a store in the same cycle
    flushEn = 1; stEn = 1; stBase = 5'd4; stDisp = 16'd2; stData = 32'h1010_1010;
    cycle("R10");
    doLoad(4, 2, "R10");
    doLoad(0, 9, "R10");

    // R9: counter wrap empties the buffer and drops a same-cycle store
    doStore(0, 100, 32'h9999_0100, "R9");
    while (mCnt != 6'd63) doNotify(31, "R9");
    doLoad(0, 100, "R9");
    regWrEn = 1; regWrIdx = 5'd31;
    stEn = 1; stBase = 5'd0; stDisp = 16'd101; stData = 32'h9999_0101;
    cycle("R9");
    doLoad(0, 100, "R9");
    doLoad(0, 101, "R9");
    doNotify(5, "R9");
    doStore(5, 7, 32'h9999_0507, "R9");
    doLoad(5, 7, "R9");

    // Random mix with a fixed seed, narrow ranges to force collisions
    void'($urandom(32'd4242));
    for (int n = 0; n < 4000; n++) begin
      regWrEn  = ($urandom % 6) == 0;
      regWrIdx = 5'($urandom % 4);
      stEn     = ($urandom % 2) == 0;
      stBase   = 5'($urandom % 4);
      stDisp   = 16'(($urandom % 6) - 2);
      stData   = $urandom;
      ldEn     = ($urandom % 4) != 0;
      ldBase   = 5'($urandom % 4);
      ldDisp   = 16'(($urandom % 6) - 2);
      flushEn  = ($urandom % 97) == 0;
      cycle("R2");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule